// File: doc/BRIEF.md
# Serial Code Lock with Attempt Budget

This block is a combination lock that receives its code one bit at a time from two push buttons. One button enters a 0 and the other enters a 1. A new press of either button produces one entry. The entry carries the bit value of the button that was pressed. A small state machine records how many leading bits of a fixed eight-bit code the recent entries have matched. When the final bit of the code arrives, the block raises a sticky unlock output.

Every entry also spends one unit of a budget of sixteen attempts. The budget is kept in a counter made of two chained three-bit stages. Once the sixteenth entry has been taken, a lockout output rises. From then on, no press reaches the matcher or the counter until the next synchronous reset. A successful unlock stays in place regardless of the lockout.

Top module: `seqlock_top`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the block returns to `progress` = 0, `unlocked` = 0 and `locked_out` = 0. These values are visible after that edge.
- R2: An entry is taken only in a cycle where at least one button is high and neither button was high in the previous cycle. A button held for several cycles gives exactly one entry.
- R3: If both buttons become high in the same cycle, the block takes one entry, and that entry carries the bit value 1.
- R4: The code is 0,1,1,0,0,0,0,0, with the leftmost bit entered first. An entry that matches the next expected code bit raises `progress` by one after the clock edge.
- R5: An entry that does not match the next expected bit sets `progress` to the length of the longest code prefix that ends the entered history. A 0 entered at progress 1 leaves progress at 1. A 1 entered at progress 0 or 3 gives progress 0.
- R6: The entry that supplies the eighth matching bit sets `unlocked` after that clock edge. `unlocked` then stays high, and `progress` stays fixed, until reset.
- R7: Every entry taken counts toward the budget, whether its bit is 0 or 1 and whether or not it matches. `locked_out` rises after the edge that takes the sixteenth entry and stays high until reset.
- R8: While `locked_out` is high, presses change neither `progress` nor `unlocked`. An unlock that happened earlier remains high.
- R9: A reset applied in the middle of an attempt clears the matched progress and the budget. A fresh sixteen entries are then available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_zero | input | 1 | Button that enters a 0 (debounced level) |
| btn_one | input | 1 | Button that enters a 1 (debounced level) |
| progress | output | 3 | Number of code bits matched so far |
| unlocked | output | 1 | Sticky flag: the full code has been entered |
| locked_out | output | 1 | Sticky flag: the sixteen-entry budget is spent |

## Verification
The assertions assume that the button inputs are clean, debounced levels that change only between clock edges. They also assume that reset is held for at least one edge before any check starts. The bench changes the buttons only on the falling clock edge. It always returns both buttons to low between presses, except where a long hold or a simultaneous press is the purpose of the test. Reset is applied only while both buttons are released, so the edge detector always starts from an idle state.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;

    localparam int CODE_LEN = 8;
    localparam int PROG_W   = $clog2(CODE_LEN);

    // Bit i is the i-th bit entered; sequence 0,1,1,0,0,0,0,0
    localparam logic [CODE_LEN-1:0] CODE = 8'b0000_0110;

    typedef logic [PROG_W-1:0] prog_t;

    typedef struct packed {
        logic valid;
        logic value;
    } entry_t;

    // Length of the longest code prefix that ends the history formed by
    // the first `matched` code bits followed by bit `b`.
    function automatic int next_prefix(input int matched, input logic b);
        int   best;
        int   p;
        logic ok;
        logic s;
        best = 0;
        for (int len = CODE_LEN; len >= 1; len--) begin
            if (best == 0 && len <= matched + 1) begin
                ok = 1'b1;
                for (int j = 0; j < CODE_LEN; j++) begin
                    if (j < len) begin
                        p = matched + 1 - len + j;
                        s = (p == matched) ? b : CODE[PROG_W'(p)];
                        if (s != CODE[PROG_W'(j)]) ok = 1'b0;
                    end
                end
                if (ok) best = len;
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/seqlock_entry.sv
module seqlock_entry
    import seqlock_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   btn_zero,
    input  logic   btn_one,
    output entry_t ent
);

    logic any_now;
    logic any_q;

    assign any_now = btn_zero | btn_one;

    always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= any_now;
    end

    always_comb begin
        ent.valid = any_now & ~any_q;
        ent.value = btn_one;
    end

    // R2
    single_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ent.valid |=> !ent.valid);

endmodule

// File: rtl/seqlock_match.sv
module seqlock_match
    import seqlock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  bit_val,
    output prog_t progress,
    output logic  unlocked
);

    prog_t progress_q;
    logic  unlocked_q;
    int    nxt;
    logic  complete;

    always_comb begin
        nxt      = next_prefix(int'(progress_q), bit_val);
        complete = (nxt == CODE_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            progress_q <= '0;
            unlocked_q <= 1'b0;
        end else if (accept && !unlocked_q) begin
            if (complete) unlocked_q <= 1'b1;
            else          progress_q <= PROG_W'(nxt);
        end
    end

    assign progress = progress_q;
    assign unlocked = unlocked_q;

    // R6
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unlocked_q |=> (unlocked_q && $stable(progress_q)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(progress_q) && $stable(unlocked_q)));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !unlocked_q && (bit_val == CODE[progress_q])
         && (progress_q != prog_t'(CODE_LEN - 1)))
        |=> (progress_q == prog_t'($past(progress_q) + 1'b1)));

endmodule

// File: rtl/seqlock_stage.sv
module seqlock_stage #(
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic done
);

    logic [W-1:0] cnt_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '1) done_q <= 1'b1;
        end
    end

    assign done = done_q;

    // R7
    stage_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

endmodule

// File: rtl/seqlock_budget.sv
module seqlock_budget #(
    parameter int STAGE_W    = 3,
    parameter int NUM_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic exhausted
);

    logic [NUM_STAGES:0]   armed;
    logic [NUM_STAGES-1:0] done;

    assign armed[0] = 1'b1;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic step;
        assign step         = accept & armed[i] & ~done[i];
        assign armed[i + 1] = done[i];
        seqlock_stage #(.W(STAGE_W)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .step (step),
            .done (done[i])
        );
    end

    assign exhausted = done[NUM_STAGES-1];

    // R7
    lockout_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(exhausted) |-> $past(accept));

endmodule

// File: rtl/seqlock_top.sv
module seqlock_top
    import seqlock_pkg::*;
#(
    parameter int STAGE_W    = 3,
    parameter int NUM_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_zero,
    input  logic              btn_one,
    output logic [PROG_W-1:0] progress,
    output logic              unlocked,
    output logic              locked_out
);

    entry_t ent;
    logic   accept;
    logic   exhausted;

    seqlock_entry u_entry (
        .clk      (clk),
        .rst      (rst),
        .btn_zero (btn_zero),
        .btn_one  (btn_one),
        .ent      (ent)
    );

    assign accept = ent.valid & ~exhausted;

    seqlock_match u_match (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .bit_val  (ent.value),
        .progress (progress),
        .unlocked (unlocked)
    );

    seqlock_budget #(
        .STAGE_W    (STAGE_W),
        .NUM_STAGES (NUM_STAGES)
    ) u_budget (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .exhausted (exhausted)
    );

    assign locked_out = exhausted;

    // R8
    blocked_chk: assert property (@(posedge clk) disable iff (rst)
        locked_out |=> ($stable(progress) && $stable(unlocked)));

endmodule

// File: tb/seqlock_top_bench.sv
module seqlock_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_zero = 1'b0;
    logic       btn_one = 1'b0;
    logic [2:0] progress;
    logic       unlocked;
    logic       locked_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int code_bits [8] = '{0, 1, 1, 0, 0, 0, 0, 0};
    int hist [$];
    int m_prog = 0;
    int m_cnt  = 0;
    bit m_unl  = 1'b0;
    bit m_lock = 1'b0;
    bit m_any  = 1'b0;

    always #4 clk = ~clk;

    seqlock_top u_seqlock_top (
        .clk        (clk),
        .rst        (rst),
        .btn_zero   (btn_zero),
        .btn_one    (btn_one),
        .progress   (progress),
        .unlocked   (unlocked),
        .locked_out (locked_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        check(req, "progress", int'(progress), m_prog);
        check(req, "unlocked", int'(unlocked), int'(m_unl));
        check(req, "locked_out", int'(locked_out), int'(m_lock));
    endtask

    function automatic int longest_prefix();
        int n = hist.size();
        for (int len = 7; len >= 1; len--) begin
            if (len <= n) begin
                bit ok = 1'b1;
                for (int j = 0; j < len; j++)
                    if (hist[n - len + j] != code_bits[j]) ok = 1'b0;
                if (ok) return len;
            end
        end
        return 0;
    endfunction

    function automatic bit full_match();
        int n = hist.size();
        if (n < 8) return 1'b0;
        for (int j = 0; j < 8; j++)
            if (hist[n - 8 + j] != code_bits[j]) return 1'b0;
        return 1'b1;
    endfunction

    // one clock with the given button levels, model update, compare
    task automatic step(input bit z, input bit o, input string req);
        bit any;
        bit entry;
        btn_zero = z;
        btn_one  = o;
        @(posedge clk);
        any   = z | o;
        entry = any && !m_any;
        m_any = any;
        if (entry && !m_lock) begin
            m_cnt++;
            if (!m_unl) begin
                hist.push_back(o ? 1 : 0);
                if (full_match()) m_unl = 1'b1;
                else              m_prog = longest_prefix();
            end
            if (m_cnt >= 16) m_lock = 1'b1;
        end
        @(negedge clk);
        compare(req);
    endtask

    task automatic press(input bit z, input bit o, input string req);
        step(z, o, req);
        step(1'b0, 1'b0, req);
    endtask

    task automatic enter(input int b, input string req);
        if (b != 0) press(1'b0, 1'b1, req);
        else        press(1'b1, 1'b0, req);
    endtask

    task automatic do_reset(input string req);
        btn_zero = 1'b0;
        btn_one  = 1'b0;
        rst      = 1'b1;
        @(posedge clk);
        hist.delete();
        m_prog = 0;
        m_cnt  = 0;
        m_unl  = 1'b0;
        m_lock = 1'b0;
        m_any  = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        compare(req);
    endtask

    initial begin
        for (int i = 0; i < 10000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R1");

        // matching and fallback
        enter(0, "R4");
        enter(0, "R5");
        enter(1, "R4");
        enter(1, "R4");
        enter(1, "R5");

        // long hold gives one entry
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, "R2");

        // both buttons together carry a 1
        press(1'b1, 1'b1, "R3");

        // mid-attempt reset
        do_reset("R9");

        // full code, then extra entries up to the budget
        for (int i = 0; i < 8; i++) enter(code_bits[i], "R6");
        enter(1, "R6");
        enter(0, "R6");
        enter(1, "R6");
        enter(0, "R6");
        for (int i = 0; i < 4; i++) enter(i % 2, "R7");
        for (int i = 0; i < 3; i++) enter(1, "R8");

        // code completed on the sixteenth entry
        do_reset("R9");
        for (int i = 0; i < 8; i++) enter(1, "R7");
        for (int i = 0; i < 8; i++) enter(code_bits[i], "R6");

        // budget spent on wrong entries, later code is blocked
        do_reset("R1");
        for (int i = 0; i < 7; i++) enter(code_bits[i], "R5");
        for (int i = 0; i < 9; i++) enter(1, "R7");
        for (int i = 0; i < 8; i++) enter(code_bits[i], "R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule